// File: doc/BRIEF.md
# Time-of-Day Counter with Pulse-Aligned Seconds Load

This block keeps wall-clock time for a line card as a seconds field and a nanoseconds field. On every reference clock cycle it adds a rate word to the nanoseconds field. The rate word is an unsigned fixed-point value with 16 fractional nanosecond bits, and a signed trim is added to it. When the nanoseconds field passes 999,999,999 it carries into the seconds field and raises a one-cycle pulse-per-second output. A servo outside this block steers the counter through three inputs. The first is a full time load, used when the counter is first set from a received timing message. The second is a one-shot signed nanosecond step. The third is the trim itself. A mode input bounds how much of the trim is applied: none while time is first being set, the full value while locking, and a small clamped value once locked.

A control-plane host can send the seconds value for the coming rollover well ahead of time. That value is held as pending. It is applied only on the rising edge of an external pulse-per-second input, so that the exact rollover instant comes from the pulse and every card changes second on the same clock. On that edge the seconds field takes the pending value and the nanoseconds field is cleared.

The full-time load, the step and the host write are valid/ready streams. The full-time load and the host write always accept, and their ready outputs are tied high. The step can be held off: its ready drops in any cycle that also carries a full-time load or a pulse-aligned load. A producer must then keep valid and the same offset until a cycle in which ready is high.

Top module: `tod_keeper`

## Requirements
- R1: While reset is asserted, the seconds and nanoseconds outputs are zero, and both the pulse output and the pending flag are low.
- R2: In a cycle with no load and no step, the internal nanoseconds-plus-fraction value grows by the effective rate word, which is Q16.16 nanoseconds. Only the integer nanoseconds appear on the output.
- R3: Mode encoding. 0 selects initial setting, and the trim is ignored. 1 selects acquisition, and the signed trim is added in full. 2 and 3 select locked operation, and the trim is first clamped to plus or minus FINE_LIM (default 0x1000, that is 1/16 ns).
- R4: The nanoseconds output never reaches 1,000,000,000. A sum at or above that value wraps and adds one to the seconds output.
- R5: The pulse output is high for exactly one cycle, the cycle in which the counter first shows a new second after a forward carry or after a pulse-aligned load. It is low in all other cycles, including after a backward borrow.
- R6: A full-time load loads seconds and nanoseconds from the request and clears the fraction. The new time is visible one cycle later with the pulse output low. The full-time load takes priority over every other update.
- R7: An accepted step adds a signed nanosecond offset (30-bit two's complement) together with that cycle's rate word, in one cycle. A borrow or carry into seconds is applied correctly.
- R8: The step ready output is low in any cycle that has a full-time load or a pulse-aligned load, and high otherwise. A step that is not accepted leaves the time unchanged except for normal counting.
- R9: A host write of seconds sets the pending flag in the next cycle. A later write before the pulse replaces the pending value.
- R10: A rising edge on the pulse input while a value is pending makes the next cycle show that seconds value with nanoseconds 0. A pending value is consumed only in a cycle with no full-time load. The pending flag clears unless a host write arrives in the same cycle, in which case the new value stays pending for the next pulse.
- R11: A rising edge of the pulse input with nothing pending has no effect on the time. Holding the pulse input high never causes a second load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Trim mode: 0 initial, 1 acquisition, 2/3 locked |
| incr_base | input | 32 | Nominal rate word, Q16.16 ns per cycle |
| freq_trim | input | 24 | Signed rate trim, Q16.16 ns |
| init_valid | input | 1 | Full-time load request |
| init_ready | output | 1 | Always high |
| init_sec | input | 48 | Seconds value to load |
| init_ns | input | 30 | Nanoseconds value to load (below 10^9) |
| step_valid | input | 1 | Step request |
| step_ready | output | 1 | Step accepted this cycle when high with valid |
| step_ns | input | 30 | Signed step offset in ns |
| sec_wr_valid | input | 1 | Host write of next-second value |
| sec_wr_ready | output | 1 | Always high |
| sec_wr_data | input | 48 | Seconds value for the next pulse |
| pps_in | input | 1 | External pulse, synchronous to clk |
| tod_sec | output | 48 | Current seconds |
| tod_ns | output | 30 | Current nanoseconds |
| pps_out | output | 1 | One-cycle rollover pulse |
| sec_pending | output | 1 | A seconds value waits for the next pulse |

## Verification
Contention between the update paths is the hardest situation to reach from the ports. A pulse edge can meet a fresh host write in the same cycle, and a step can be waiting while a pulse-aligned load happens. The stimulus reaches these cases by lowering the pulse input and queueing a write. It then raises the pulse input together with either a second write or an asserted step. Afterwards it checks that the old value was applied and that the new one stays pending, or that the step was held and then applied in the next cycle with a borrow across the freshly loaded second.

// File: rtl/tod_pkg.sv
package tod_pkg;

  localparam longint NS_PER_SEC = 64'd1_000_000_000;

  typedef enum logic [1:0] {
    MODE_INIT  = 2'd0,
    MODE_ACQ   = 2'd1,
    MODE_LOCK  = 2'd2,
    MODE_LOCK2 = 2'd3
  } tod_mode_e;

endpackage

// File: rtl/tod_rate_sel.sv
// Builds the effective per-cycle rate word from the nominal word and the
// servo trim, with the trim scaled back according to the operating mode.
module tod_rate_sel
  import tod_pkg::*;
#(
  parameter int INC_W    = 32,
  parameter int TRIM_W   = 24,
  parameter int FINE_LIM = 32'h1000
) (
  input  logic [1:0]               mode,
  input  logic [INC_W-1:0]         base,
  input  logic signed [TRIM_W-1:0] trim,
  output logic [INC_W-1:0]         inc_eff
);
  localparam int SW = INC_W + 2;
  localparam logic signed [TRIM_W-1:0] LIM_P = TRIM_W'(FINE_LIM);
  localparam logic signed [TRIM_W-1:0] LIM_N = -LIM_P;

  logic signed [TRIM_W-1:0] trim_sel;
  logic signed [SW-1:0]     sum;

  always_comb begin
    case (mode)
      MODE_INIT: trim_sel = '0;
      MODE_ACQ:  trim_sel = trim;
      default: begin
        if (trim > LIM_P)      trim_sel = LIM_P;
        else if (trim < LIM_N) trim_sel = LIM_N;
        else                   trim_sel = trim;
      end
    endcase
  end

  always_comb begin
    sum = $signed({2'b00, base}) + SW'(trim_sel);
    if (sum < 0)                  inc_eff = '0;
    else if (|sum[SW-1:INC_W])    inc_eff = '1;
    else                          inc_eff = sum[INC_W-1:0];
  end

endmodule

// File: rtl/tod_accum.sv
// Next-time arithmetic: adds the rate word and an optional signed step to
// the nanosecond+fraction value and resolves one carry or borrow into seconds.
module tod_accum
  import tod_pkg::*;
#(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int FRAC_W = 16,
  parameter int INC_W  = 32,
  parameter int STEP_W = 30
) (
  input  logic [SEC_W-1:0]         sec,
  input  logic [NS_W-1:0]          ns,
  input  logic [FRAC_W-1:0]        frac,
  input  logic [INC_W-1:0]         inc,
  input  logic                     step_en,
  input  logic signed [STEP_W-1:0] step_ns,
  output logic [SEC_W-1:0]         nsec,
  output logic [NS_W-1:0]          nns,
  output logic [FRAC_W-1:0]        nfrac,
  output logic                     carry
);
  localparam int FW  = NS_W + FRAC_W;
  localparam int SFW = STEP_W + FRAC_W;
  localparam int AW  = ((FW > SFW) ? FW : SFW) + 2;
  localparam logic signed [AW-1:0] LIMIT = AW'(NS_PER_SEC) <<< FRAC_W;

  logic signed [AW-1:0] cur, stepv, sum, fix;

  always_comb begin
    cur   = $signed({{(AW-FW){1'b0}}, ns, frac});
    stepv = step_en ? (AW'(step_ns) <<< FRAC_W) : '0;
    sum   = cur + $signed({{(AW-INC_W){1'b0}}, inc}) + stepv;
    carry = 1'b0;
    nsec  = sec;
    fix   = sum;
    if (sum < 0) begin
      fix  = sum + LIMIT;
      nsec = sec - SEC_W'(1);
    end else if (sum >= LIMIT) begin
      fix   = sum - LIMIT;
      nsec  = sec + SEC_W'(1);
      carry = 1'b1;
    end
    nns   = NS_W'(fix >>> FRAC_W);
    nfrac = FRAC_W'(fix);
  end

endmodule

// File: rtl/tod_align.sv
// Holds the host-supplied seconds value and releases it on a rising edge
// of the external pulse.
module tod_align #(
  parameter int SEC_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pps_in,
  input  logic             hold,
  input  logic             wr_valid,
  input  logic [SEC_W-1:0] wr_data,
  output logic             load_go,
  output logic [SEC_W-1:0] pend_sec,
  output logic             pend_vld
);
  logic pps_prev;
  logic pps_edge;

  assign pps_edge = pps_in & ~pps_prev;
  assign load_go  = pps_edge & pend_vld & ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pps_prev <= 1'b0;
      pend_sec <= '0;
      pend_vld <= 1'b0;
    end else begin
      pps_prev <= pps_in;
      if (wr_valid) begin
        pend_sec <= wr_data;
        pend_vld <= 1'b1;
      end else if (load_go) begin
        pend_vld <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tod_keeper.sv
module tod_keeper
  import tod_pkg::*;
#(
  parameter int SEC_W    = 48,
  parameter int NS_W     = 30,
  parameter int FRAC_W   = 16,
  parameter int INC_W    = 32,
  parameter int TRIM_W   = 24,
  parameter int STEP_W   = 30,
  parameter int FINE_LIM = 32'h1000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode,
  input  logic [INC_W-1:0]         incr_base,
  input  logic signed [TRIM_W-1:0] freq_trim,
  input  logic                     init_valid,
  output logic                     init_ready,
  input  logic [SEC_W-1:0]         init_sec,
  input  logic [NS_W-1:0]          init_ns,
  input  logic                     step_valid,
  output logic                     step_ready,
  input  logic signed [STEP_W-1:0] step_ns,
  input  logic                     sec_wr_valid,
  output logic                     sec_wr_ready,
  input  logic [SEC_W-1:0]         sec_wr_data,
  input  logic                     pps_in,
  output logic [SEC_W-1:0]         tod_sec,
  output logic [NS_W-1:0]          tod_ns,
  output logic                     pps_out,
  output logic                     sec_pending
);
  logic [SEC_W-1:0]  sec_q;
  logic [NS_W-1:0]   ns_q;
  logic [FRAC_W-1:0] frac_q;
  logic              pps_q;

  logic [INC_W-1:0]  inc_eff;
  logic [SEC_W-1:0]  nsec;
  logic [NS_W-1:0]   nns;
  logic [FRAC_W-1:0] nfrac;
  logic              carry;
  logic              load_go;
  logic [SEC_W-1:0]  pend_sec;
  logic              step_fire;

  assign init_ready   = 1'b1;
  assign sec_wr_ready = 1'b1;
  assign step_ready   = ~init_valid & ~load_go;
  assign step_fire    = step_valid & step_ready;

  tod_rate_sel #(
    .INC_W(INC_W), .TRIM_W(TRIM_W), .FINE_LIM(FINE_LIM)
  ) u_rate (
    .mode(mode), .base(incr_base), .trim(freq_trim), .inc_eff(inc_eff)
  );

  tod_accum #(
    .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .INC_W(INC_W), .STEP_W(STEP_W)
  ) u_accum (
    .sec(sec_q), .ns(ns_q), .frac(frac_q), .inc(inc_eff),
    .step_en(step_fire), .step_ns(step_ns),
    .nsec(nsec), .nns(nns), .nfrac(nfrac), .carry(carry)
  );

  tod_align #(.SEC_W(SEC_W)) u_align (
    .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .hold(init_valid),
    .wr_valid(sec_wr_valid), .wr_data(sec_wr_data),
    .load_go(load_go), .pend_sec(pend_sec), .pend_vld(sec_pending)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      ns_q   <= '0;
      frac_q <= '0;
      pps_q  <= 1'b0;
    end else if (init_valid) begin
      sec_q  <= init_sec;
      ns_q   <= init_ns;
      frac_q <= '0;
      pps_q  <= 1'b0;
    end else if (load_go) begin
      sec_q  <= pend_sec;
      ns_q   <= '0;
      frac_q <= '0;
      pps_q  <= 1'b1;
    end else begin
      sec_q  <= nsec;
      ns_q   <= nns;
      frac_q <= nfrac;
      pps_q  <= carry;
    end
  end

  assign tod_sec = sec_q;
  assign tod_ns  = ns_q;
  assign pps_out = pps_q;

endmodule

// File: rtl/tod_keeper_chk.sv
module tod_keeper_chk
  import tod_pkg::*;
#(
  parameter int SEC_W = 48,
  parameter int NS_W  = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init_valid,
  input logic [SEC_W-1:0] init_sec,
  input logic [NS_W-1:0]  init_ns,
  input logic             step_valid,
  input logic             step_ready,
  input logic             sec_wr_valid,
  input logic             load_go,
  input logic [SEC_W-1:0] pend_sec,
  input logic [SEC_W-1:0] tod_sec,
  input logic [NS_W-1:0]  tod_ns,
  input logic             pps_out,
  input logic             sec_pending
);

  a_r4_ns_range: assert property (@(posedge clk) disable iff (!rst_n)
    64'(tod_ns) < 64'(NS_PER_SEC));

  a_r5_pps_single: assert property (@(posedge clk) disable iff (!rst_n)
    pps_out |=> !pps_out);

  a_r5_pps_tracks_sec: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_valid && !load_go && !(step_valid && step_ready))
      |=> (pps_out == (tod_sec != $past(tod_sec))));

  a_r6_init_load: assert property (@(posedge clk) disable iff (!rst_n)
    init_valid |=> (tod_sec == $past(init_sec) && tod_ns == $past(init_ns) && !pps_out));

  a_r8_step_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (init_valid || load_go) |-> !step_ready);

  a_r9_write_pends: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wr_valid |=> sec_pending);

  a_r10_pulse_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> (tod_sec == $past(pend_sec) && tod_ns == '0 && pps_out));

  a_r10_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (load_go && !sec_wr_valid) |=> !sec_pending);

endmodule

bind tod_keeper tod_keeper_chk #(.SEC_W(SEC_W), .NS_W(NS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .init_valid(init_valid), .init_sec(init_sec),
  .init_ns(init_ns), .step_valid(step_valid), .step_ready(step_ready),
  .sec_wr_valid(sec_wr_valid), .load_go(load_go), .pend_sec(pend_sec),
  .tod_sec(tod_sec), .tod_ns(tod_ns), .pps_out(pps_out), .sec_pending(sec_pending)
);

// File: tb/tb_tod_keeper.sv
module tb_tod_keeper;
  localparam int CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [1:0]         mode = 2'd0;
  logic [31:0]        incr_base = 32'h0008_0000;
  logic signed [23:0] freq_trim = '0;
  logic               init_valid = 1'b0;
  logic               init_ready;
  logic [47:0]        init_sec = '0;
  logic [29:0]        init_ns = '0;
  logic               step_valid = 1'b0;
  logic               step_ready;
  logic signed [29:0] step_ns = '0;
  logic               sec_wr_valid = 1'b0;
  logic               sec_wr_ready;
  logic [47:0]        sec_wr_data = '0;
  logic               pps_in = 1'b0;
  logic [47:0]        tod_sec;
  logic [29:0]        tod_ns;
  logic               pps_out;
  logic               sec_pending;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_keeper dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .incr_base(incr_base),
    .freq_trim(freq_trim), .init_valid(init_valid), .init_ready(init_ready),
    .init_sec(init_sec), .init_ns(init_ns), .step_valid(step_valid),
    .step_ready(step_ready), .step_ns(step_ns), .sec_wr_valid(sec_wr_valid),
    .sec_wr_ready(sec_wr_ready), .sec_wr_data(sec_wr_data), .pps_in(pps_in),
    .tod_sec(tod_sec), .tod_ns(tod_ns), .pps_out(pps_out), .sec_pending(sec_pending)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int ncyc = 0;
  bit done = 1'b0;

  int     q_cyc[$];
  longint q_sec[$];
  longint q_ns[$];
  bit     q_pps[$];
  bit     q_pnd[$];
  string  q_tag[$];

  always @(posedge clk) ncyc++;

  // Driver side: push one expected snapshot for the current cycle.
  task automatic expect_st(string tag, longint s, longint n, bit p, bit pd);
    q_cyc.push_back(ncyc);
    q_sec.push_back(s);
    q_ns.push_back(n);
    q_pps.push_back(p);
    q_pnd.push_back(pd);
    q_tag.push_back(tag);
  endtask

  // Monitor side: compare away from the active edge.
  always @(negedge clk) begin
    while (q_cyc.size() > 0 && q_cyc[0] <= ncyc) begin
      string  tg;
      longint es, en;
      bit     ep, epd;
      void'(q_cyc.pop_front());
      es = q_sec.pop_front();
      en = q_ns.pop_front();
      ep = q_pps.pop_front();
      epd = q_pnd.pop_front();
      tg = q_tag.pop_front();
      n_cmp++;
      if (longint'(tod_sec) != es || longint'(tod_ns) != en ||
          pps_out != ep || sec_pending != epd) begin
        n_bad++;
        $display("FAIL %s: got sec=%0d ns=%0d pps=%0b pend=%0b, expected sec=%0d ns=%0d pps=%0b pend=%0b",
                 tg, tod_sec, tod_ns, pps_out, sec_pending, es, en, ep, epd);
      end
    end
  end

  task automatic chk_bit(string tag, bit act, bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b, expected %0b", tag, act, exp);
    end
  endtask

  task automatic clk1();
    @(posedge clk);
    #1;
  endtask

  task automatic clkn(int n);
    for (int i = 0; i < n; i++) clk1();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    clk1(); clk1();
    expect_st("R1 reset state", 0, 0, 0, 0);
    chk_bit("R6 init_ready tied", init_ready, 1'b1);
    chk_bit("R9 sec_wr_ready tied", sec_wr_ready, 1'b1);
    rst_n = 1'b1;
    clk1();
    expect_st("R2 first advance", 0, 8, 0, 0);

    init_valid = 1'b1; init_sec = 48'd100; init_ns = 30'd500;
    clk1();
    init_valid = 1'b0;
    expect_st("R6 full load", 100, 500, 0, 0);
    clkn(3);
    expect_st("R2 counting", 100, 524, 0, 0);

    freq_trim = 24'sh008000; mode = 2'd0;
    clkn(4);
    expect_st("R3 trim ignored in init mode", 100, 556, 0, 0);
    mode = 2'd1;
    clkn(4);
    expect_st("R3 full trim in acquisition", 100, 590, 0, 0);
    mode = 2'd2;
    clkn(16);
    expect_st("R3 positive clamp when locked", 100, 719, 0, 0);
    freq_trim = -24'sh008000;
    clkn(16);
    expect_st("R3 negative clamp when locked", 100, 846, 0, 0);
    mode = 2'd0; freq_trim = '0;

    init_valid = 1'b1; init_sec = 48'd5; init_ns = 30'd999_999_990;
    clk1();
    init_valid = 1'b0;
    expect_st("R6 load near wrap", 5, 999_999_990, 0, 0);
    clk1();
    expect_st("R4 just below wrap", 5, 999_999_998, 0, 0);
    clk1();
    expect_st("R4 R5 wrap into seconds", 6, 6, 1, 0);
    clk1();
    expect_st("R5 pulse one cycle", 6, 14, 0, 0);

    init_valid = 1'b1; init_sec = 48'd7; init_ns = 30'd999_999_000;
    clk1();
    init_valid = 1'b0;
    step_valid = 1'b1; step_ns = 30'sd5000;
    #1 chk_bit("R8 step ready when idle", step_ready, 1'b1);
    clk1();
    step_valid = 1'b0;
    expect_st("R7 step carry", 8, 4008, 1, 0);
    step_valid = 1'b1; step_ns = -30'sd10000;
    clk1();
    step_valid = 1'b0;
    expect_st("R7 R5 step borrow no pulse", 7, 999_994_016, 0, 0);

    init_valid = 1'b1; init_sec = 48'd9; init_ns = 30'd0;
    step_valid = 1'b1; step_ns = 30'sd1000;
    #1 chk_bit("R8 step blocked by full load", step_ready, 1'b0);
    clk1();
    init_valid = 1'b0; step_valid = 1'b0;
    expect_st("R8 blocked step not applied", 9, 0, 0, 0);

    sec_wr_valid = 1'b1; sec_wr_data = 48'd1000;
    clk1();
    sec_wr_valid = 1'b0;
    expect_st("R9 write sets pending", 9, 8, 0, 1);
    pps_in = 1'b1;
    clk1();
    expect_st("R10 pulse-aligned load", 1000, 0, 1, 0);
    clk1();
    expect_st("R11 held pulse no reload", 1000, 8, 0, 0);
    pps_in = 1'b0;
    clk1();
    expect_st("R11 pulse low", 1000, 16, 0, 0);
    pps_in = 1'b1;
    clk1();
    expect_st("R11 edge with nothing pending", 1000, 24, 0, 0);

    pps_in = 1'b0; sec_wr_valid = 1'b1; sec_wr_data = 48'd2000;
    clk1();
    expect_st("R9 first write", 1000, 32, 0, 1);
    sec_wr_data = 48'd3000;
    clk1();
    sec_wr_valid = 1'b0;
    expect_st("R9 second write", 1000, 40, 0, 1);
    pps_in = 1'b1;
    clk1();
    expect_st("R9 later write replaced earlier", 3000, 0, 1, 0);

    pps_in = 1'b0;
    clk1();
    expect_st("R2 after load", 3000, 8, 0, 0);
    sec_wr_valid = 1'b1; sec_wr_data = 48'd4000;
    clk1();
    sec_wr_valid = 1'b0;
    expect_st("R9 queue 4000", 3000, 16, 0, 1);
    pps_in = 1'b1; sec_wr_valid = 1'b1; sec_wr_data = 48'd5000;
    clk1();
    sec_wr_valid = 1'b0;
    expect_st("R10 load old value, new stays pending", 4000, 0, 1, 1);
    pps_in = 1'b0;
    clk1();
    expect_st("R10 pending kept", 4000, 8, 0, 1);
    pps_in = 1'b1;
    clk1();
    expect_st("R10 second pulse applies new value", 5000, 0, 1, 0);

    pps_in = 1'b0; sec_wr_valid = 1'b1; sec_wr_data = 48'd6000;
    clk1();
    sec_wr_valid = 1'b0;
    expect_st("R9 queue 6000", 5000, 8, 0, 1);
    pps_in = 1'b1; step_valid = 1'b1; step_ns = -30'sd100;
    #1 chk_bit("R8 step blocked by pulse load", step_ready, 1'b0);
    clk1();
    expect_st("R8 R10 load wins over step", 6000, 0, 1, 0);
    chk_bit("R8 step ready after load", step_ready, 1'b1);
    clk1();
    step_valid = 1'b0;
    expect_st("R7 held step borrows across new second", 5999, 999_999_908, 0, 0);

    clkn(2);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule